// File: doc/BRIEF.md
# Word-Serial Bignum Scalar Multiply-Accumulate Unit

This unit multiplies a long unsigned number, held as a run of 16-bit words with the least significant word at address 0, by one 16-bit scalar. It walks the words one at a time. At each step it forms the 32-bit product of the current word and the scalar, plus the high half carried from the step before. It writes a 16-bit word back to the destination number and carries a 16-bit word forward. Three operations share this one datapath. The first stores the plain product. The second adds the product into the destination. The third subtracts the product from the destination. In every operation the final carried word comes back on `result`.

Both numbers sit in external single-word memories with a one-cycle read latency. The source port is read-only. The destination has a read port and a write port, so it maps onto a simple dual-port block RAM. Each word takes a read phase followed by a write phase. The caller pulses `start` with the operation, the scalar and the length in words, then waits for the one-cycle `done` pulse.

Top module: `bignum_mac`

## Requirements
- R1: With `mode` = 2'b00 (product), destination word i becomes the low 16 bits of the running product, for i = 0..n-1. The final high word is written at destination address n and also returned on `result`. The value 2'b11 behaves as product.
- R2: With `mode` = 2'b01 (accumulate), the low half is added into destination word i, and the carry-out of that addition is added into the word carried forward. The final carried word is returned on `result`, and destination address n is left unchanged.
- R3: With `mode` = 2'b10 (subtract), the low half is subtracted from destination word i, and the borrow-out is added into the word carried forward. The final word is returned on `result` as the borrow, and destination address n is left unchanged.
- R4: A length of 1 gives correct results in all three modes, including when every operand is 16'hFFFF.
- R5: A start with length 0 raises `done` on the next cycle with `result` = 0. It writes nothing and does not raise `busy`.
- R6: Each word has a one-cycle read phase (`src_rd`) and then a write phase, at the same address. `done` is visible 2n+1 cycles after the start edge in accumulate and subtract, and 2n+2 cycles after it in product.
- R7: `start` is ignored while `busy` is high. Mode, scalar and length are captured at the accepted start.
- R8: After reset, `busy`, `done`, `src_rd`, `dst_rd` and `dst_we` are all low.
- R9: `done` lasts exactly one cycle, and `result` holds its value until the next start is accepted.
- R10: In product mode the destination read port is never enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 2 | 00 product, 01 accumulate, 10 subtract |
| scalar | input | 16 | Scalar multiplier |
| length | input | 17 | Number of words, 0..65536 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Final carry or borrow word |
| src_rd | output | 1 | Source read enable |
| src_addr | output | 17 | Source word address |
| src_rdata | input | 16 | Source data, one cycle after the read |
| dst_rd | output | 1 | Destination read enable |
| dst_raddr | output | 17 | Destination read address |
| dst_rdata | input | 16 | Destination data, one cycle after the read |
| dst_we | output | 1 | Destination write enable |
| dst_waddr | output | 17 | Destination write address |
| dst_wdata | output | 16 | Destination write data |

## Verification
A corrupted carry register shows up as a wrong data word on the very next write strobe, and every later word is wrong too. So the bench compares every destination write against its model, in the cycle the write happens. A wrong word index or phase state shows as a wrong write address, a missing or extra write, or a misplaced read strobe within one to two cycles. A bad length or end-of-run decision moves the `done` pulse away from its expected cycle count. A start that should have been ignored but was latched changes the data of the writes that follow.

// File: rtl/bnm_pkg.sv
package bnm_pkg;
  typedef enum logic [1:0] {
    OP_MUL = 2'b00,
    OP_ADD = 2'b01,
    OP_SUB = 2'b10
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_READ,
    S_WRITE,
    S_TAIL
  } st_e;
endpackage

// File: rtl/bnm_step.sv
// One word step: product plus incoming high word, then store/add/subtract.
module bnm_step
  import bnm_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] k,
  input  logic [W-1:0] dst,
  input  logic [W-1:0] cin,
  output logic [W-1:0] wout,
  output logic [W-1:0] cout
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod;
  logic [W-1:0]  lo, hi;
  logic [W:0]    sum, diff;

  always_comb begin
    prod = {{W{1'b0}}, a} * {{W{1'b0}}, k} + {{W{1'b0}}, cin};
    lo   = prod[W-1:0];
    hi   = prod[PW-1:W];
    sum  = {1'b0, dst} + {1'b0, lo};
    diff = {1'b0, dst} - {1'b0, lo};
    case (op)
      OP_ADD: begin
        wout = sum[W-1:0];
        cout = hi + {{(W-1){1'b0}}, sum[W]};
      end
      OP_SUB: begin
        wout = diff[W-1:0];
        cout = hi + {{(W-1){1'b0}}, diff[W]};
      end
      default: begin
        wout = lo;
        cout = hi;
      end
    endcase
  end
endmodule

// File: rtl/bnm_ctrl.sv
// Phase sequencer: read phase, write phase per word, optional tail write.
module bnm_ctrl
  import bnm_pkg::*;
#(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [LEN_W-1:0] length,
  output st_e              st,
  output op_e              op_q,
  output logic [LEN_W-1:0] idx,
  output logic             last,
  output logic             accept,
  output logic             done
);
  logic [LEN_W-1:0] len_q;

  assign accept = (st == S_IDLE) && start;
  assign last   = (idx == len_q - {{(LEN_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      op_q  <= OP_MUL;
      idx   <= '0;
      len_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (length == '0) begin
              done <= 1'b1;
            end else begin
              st    <= S_READ;
              idx   <= '0;
              len_q <= length;
              op_q  <= (mode == 2'b11) ? OP_MUL : op_e'(mode);
            end
          end
        end
        S_READ: st <= S_WRITE;
        S_WRITE: begin
          idx <= idx + 1'b1;
          if (!last) begin
            st <= S_READ;
          end else if (op_q == OP_MUL) begin
            st <= S_TAIL;
          end else begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        default: begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/bignum_mac.sv
module bignum_mac
  import bnm_pkg::*;
#(
  parameter int W     = 16,
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [W-1:0]     scalar,
  input  logic [LEN_W-1:0] length,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     result,
  output logic             src_rd,
  output logic [LEN_W-1:0] src_addr,
  input  logic [W-1:0]     src_rdata,
  output logic             dst_rd,
  output logic [LEN_W-1:0] dst_raddr,
  input  logic [W-1:0]     dst_rdata,
  output logic             dst_we,
  output logic [LEN_W-1:0] dst_waddr,
  output logic [W-1:0]     dst_wdata
);
  st_e              st;
  op_e              op_q;
  logic [LEN_W-1:0] idx;
  logic             last, accept;
  logic [W-1:0]     k_q, carry_q, result_q;
  logic [W-1:0]     step_w, step_c;

  bnm_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .length(length),
    .st(st), .op_q(op_q), .idx(idx), .last(last), .accept(accept),
    .done(done)
  );

  bnm_step #(.W(W)) u_step (
    .op(op_q), .a(src_rdata), .k(k_q), .dst(dst_rdata), .cin(carry_q),
    .wout(step_w), .cout(step_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q      <= '0;
      carry_q  <= '0;
      result_q <= '0;
    end else begin
      if (accept) begin
        k_q     <= scalar;
        carry_q <= '0;
        if (length == '0) result_q <= '0;
      end
      if (st == S_WRITE) begin
        carry_q <= step_c;
        if (last && op_q != OP_MUL) result_q <= step_c;
      end
      if (st == S_TAIL) result_q <= carry_q;
    end
  end

  assign busy      = (st != S_IDLE);
  assign result    = result_q;
  assign src_rd    = (st == S_READ);
  assign src_addr  = idx;
  assign dst_rd    = (st == S_READ) && (op_q != OP_MUL);
  assign dst_raddr = idx;
  assign dst_we    = (st == S_WRITE) || (st == S_TAIL);
  assign dst_waddr = idx;
  assign dst_wdata = (st == S_TAIL) ? carry_q : step_w;
endmodule

// File: rtl/bignum_mac_chk.sv
module bignum_mac_chk #(
  parameter int W     = 16,
  parameter int LEN_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [LEN_W-1:0] length,
  input logic             busy,
  input logic             done,
  input logic [W-1:0]     result,
  input logic             src_rd,
  input logic [LEN_W-1:0] src_addr,
  input logic             dst_rd,
  input logic             dst_we,
  input logic [LEN_W-1:0] dst_waddr
);
  // R6: a read phase is always followed by a write phase
  p_read_then_write_r6: assert property (@(posedge clk) disable iff (rst)
    src_rd |=> (dst_we && !src_rd));

  // R6: the write lands at the address just read
  p_write_addr_r6: assert property (@(posedge clk) disable iff (rst)
    src_rd |=> (dst_waddr == $past(src_addr)));

  // R5: zero length finishes at once with a zero word
  p_zero_len_r5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && length == '0) |=> (done && result == '0 && !busy));

  // R8: no memory activity while idle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!dst_we && !src_rd && !dst_rd));

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: result holds between completions while idle
  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(!busy) && !busy && !done && !$past(start)) |-> $stable(result));
endmodule

bind bignum_mac bignum_mac_chk #(.W(W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .length(length), .busy(busy),
  .done(done), .result(result), .src_rd(src_rd), .src_addr(src_addr),
  .dst_rd(dst_rd), .dst_we(dst_we), .dst_waddr(dst_waddr)
);

// File: tb/bignum_mac_tb.sv
`timescale 1ns/1ps
module bignum_mac_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] scalar = '0;
  logic [16:0] length = '0;
  logic        busy, done, src_rd, dst_rd, dst_we;
  logic [15:0] result, dst_wdata;
  logic [15:0] src_rdata = '0, dst_rdata = '0;
  logic [16:0] src_addr, dst_raddr, dst_waddr;

  always #5 clk = ~clk;

  bignum_mac u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .scalar(scalar),
    .length(length), .busy(busy), .done(done), .result(result),
    .src_rd(src_rd), .src_addr(src_addr), .src_rdata(src_rdata),
    .dst_rd(dst_rd), .dst_raddr(dst_raddr), .dst_rdata(dst_rdata),
    .dst_we(dst_we), .dst_waddr(dst_waddr), .dst_wdata(dst_wdata)
  );

  logic [15:0] src_mem [0:63];
  logic [15:0] dst_mem [0:63];
  logic [15:0] exp_mem [0:63];
  int          exp_addr[$];
  int          exp_data[$];
  int          checks = 0, errors = 0;
  int          cur_mode = 0;
  string       cur_tag = "R1";

  always @(posedge clk) begin
    if (src_rd) src_rdata <= src_mem[src_addr[5:0]];
    if (dst_rd) dst_rdata <= dst_mem[dst_raddr[5:0]];
    if (dst_we) dst_mem[dst_waddr[5:0]] <= dst_wdata;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of write strobes against the model queue
  always @(negedge clk) begin
    if (!rst && dst_we) begin
      if (exp_addr.size() == 0) chk(0, cur_tag, dst_waddr, -1);
      else begin
        int ea, ed;
        ea = exp_addr.pop_front();
        ed = exp_data.pop_front();
        chk(dst_waddr == ea && dst_wdata == ed, cur_tag,
            {dst_waddr, dst_wdata}, {ea[16:0], ed[15:0]});
      end
    end
    if (!rst && dst_rd && cur_mode == 0) chk(0, "R10", 1, 0);
  end

  task automatic run(input int md, input int k, input int n, input string tag, input bit intrude);
    longint c = 0;
    int     cnt, expc, eff;
    cur_tag = tag;
    eff = (md == 3) ? 0 : md;
    cur_mode = eff;
    for (int i = 0; i < 64; i++) exp_mem[i] = dst_mem[i];
    for (int i = 0; i < n; i++) begin
      longint p, lo, d, o;
      p  = longint'(src_mem[i]) * k + c;
      lo = p & 'hFFFF;
      d  = dst_mem[i];
      if (eff == 1) begin
        o = (d + lo) & 'hFFFF;
        c = (p >> 16) + ((d + lo) >> 16);
      end else if (eff == 2) begin
        o = (d - lo) & 'hFFFF;
        c = (p >> 16) + ((lo > d) ? 1 : 0);
      end else begin
        o = lo;
        c = p >> 16;
      end
      exp_mem[i] = o[15:0];
      exp_addr.push_back(i);
      exp_data.push_back(int'(o));
    end
    if (eff == 0 && n > 0) begin
      exp_mem[n] = c[15:0];
      exp_addr.push_back(n);
      exp_data.push_back(int'(c));
    end
    if (n == 0) c = 0;
    expc = (n == 0) ? 1 : ((eff == 0) ? 2*n + 2 : 2*n + 1);
    @(negedge clk);
    start = 1; mode = md[1:0]; scalar = k[15:0]; length = n[16:0];
    @(negedge clk);
    cnt = 1;
    start = 0;
    while (!done && cnt < 1000) begin
      if (intrude && cnt == 2) begin
        start = 1; mode = 2'b10; scalar = 16'h1234; length = 17'd1;
      end else start = 0;
      @(negedge clk);
      cnt++;
    end
    start = 0;
    chk(cnt == expc, "R6", cnt, expc);
    chk(result == c[15:0], tag, result, c[15:0]);
    chk(exp_addr.size() == 0, tag, exp_addr.size(), 0);
    repeat (3) @(negedge clk);
    chk(result == c[15:0] && !done, "R9", result, c[15:0]);
    for (int i = 0; i < 64; i++)
      if (dst_mem[i] != exp_mem[i]) chk(0, tag, dst_mem[i], exp_mem[i]);
    checks++;
  endtask

  task automatic fill(input int ones);
    for (int i = 0; i < 64; i++) begin
      src_mem[i] = ones ? 16'hFFFF : 16'($urandom);
      dst_mem[i] = ones ? 16'hFFFF : 16'($urandom);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    fill(0);
    repeat (4) @(negedge clk);
    chk(!busy && !done && !dst_we && !src_rd && !dst_rd, "R8",
        {busy, done, dst_we, src_rd, dst_rd}, 0);
    rst = 0;
    @(negedge clk);
    // R1 product
    run(0, 16'hBEEF, 5, "R1", 0);
    fill(0); run(0, 16'h0000, 4, "R1", 0);
    fill(0); run(3, 16'h7001, 3, "R1", 0);
    // R2 accumulate
    fill(0); run(1, 16'hA5A5, 8, "R2", 0);
    // R3 subtract
    fill(0); run(2, 16'hFFFF, 6, "R3", 0);
    fill(0);
    for (int i = 0; i < 64; i++) dst_mem[i] = 16'h0000;
    run(2, 16'h0003, 4, "R3", 0);
    // R4 length one, all ones
    fill(1); run(0, 16'hFFFF, 1, "R4", 0);
    fill(1); run(1, 16'hFFFF, 1, "R4", 0);
    fill(1); run(2, 16'hFFFF, 1, "R4", 0);
    // R5 zero length: no writes, result 0
    fill(0); run(1, 16'h1111, 0, "R5", 0);
    chk(!busy, "R5", busy, 0);
    // R7 start while busy is ignored
    fill(0); run(1, 16'h4321, 6, "R7", 1);
    fill(0); run(0, 16'h0102, 7, "R7", 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule